// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

A 16-bit field manipulation unit with two operations driven by a single control byte. An extract operation takes a field out of operand A and returns it right-justified, with every bit above the field cleared. An insert operation takes the low bits of operand B and places them into a field of operand A, leaving all other bits of A as they were. The merged word is returned as the result.

The control byte gives the field's bit offset and its width. Both operations share one datapath, a left rotator followed by a field mask. A small generator turns the control byte and the operation into a packed shift-control word. That word holds a rotate count, an upper-mask count and a lower-mask count. A caller pulses `start_i` with the operands valid. The result and a `done_o` pulse appear one clock later.

Top module: `bfu_field_unit`

## Requirements
- R1: In `ctrl_i`, bits 3:0 are the field offset (shift) and bits 7:4 are the field width. A width code of 0 means a 16-bit field.
- R2: Extract (`op_i`=0) returns `result_o[i] = a_i[(i+shift) mod 16]` for i below the width, and 0 for every bit at or above the width. A field that runs past bit 15 wraps around to the low bits of A.
- R3: `done_o` is 1 exactly in the cycle after a cycle with `start_i`=1, and 0 otherwise.
- R4: Insert (`op_i`=1) leaves every bit of A outside the field, bits shift to shift+width-1, unchanged in `result_o`.
- R5: Insert places `b_i[width-1:0]` into `result_o[shift+width-1:shift]`.
- R6: When shift+width exceeds 16, insert truncates the field at bit 15. Only `b_i[15-shift:0]` is written, and no bit wraps into the low end.
- R7: With width code 0, extract returns A rotated right by shift, and insert replaces bits 15 to shift of A.
- R8: While `rst_ni` is low, `result_o` and `done_o` are 0.
- R9: `result_o` keeps its value in any cycle that follows a cycle with `start_i`=0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation on the current inputs |
| op_i | input | 1 | 0 = extract, 1 = insert |
| ctrl_i | input | 8 | Field descriptor: [3:0] shift, [7:4] width (0 = 16) |
| a_i | input | 16 | Operand A, the source word or the word being modified |
| b_i | input | 16 | Operand B, the insert data in its low bits |
| result_o | output | 16 | Registered result |
| done_o | output | 1 | One-cycle pulse, one clock after start |

## Verification
The hardest case to reach is the one where the upper-mask count must saturate: an insert whose shift plus width passes bit 15. The width-0 encoding, where a mask count of 16 has to fold to no masking, is just as hard. Random control bytes hit these cases only by chance. The stimulus therefore sweeps all 256 control-byte values for both operations with pseudo-random operands. It also uses directed vectors that put wrapped and truncated fields next to all-ones and all-zeros operands, so that a stray or missing masked bit shows up.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    OP_EXTRACT = 1'b0,
    OP_INSERT  = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_ctl_gen.sv
// Shift-control word generator: rotate count, upper-mask count, lower-mask count
module bfu_ctl_gen
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W),
  localparam int unsigned EXT_W = CNT_W + 2
) (
  input  bfu_op_e            op_i,
  input  logic [2*CNT_W-1:0] ctrl_i,
  output logic [CNT_W-1:0]   rot_o,
  output logic [CNT_W-1:0]   lcnt_o,
  output logic [CNT_W-1:0]   rcnt_o
);
  logic [CNT_W-1:0] shift;
  logic [CNT_W-1:0] wid_code;
  logic [EXT_W-1:0] wid_eff;
  logic [EXT_W-1:0] span;
  logic [EXT_W-1:0] ext_l;
  logic [EXT_W-1:0] ins_l;

  assign shift    = ctrl_i[CNT_W-1:0];
  assign wid_code = ctrl_i[2*CNT_W-1:CNT_W];
  assign wid_eff  = (wid_code == '0) ? EXT_W'(DATA_W) : EXT_W'(wid_code);
  assign span     = wid_eff + EXT_W'(shift);
  assign ext_l    = EXT_W'(DATA_W) - wid_eff;
  // saturate: field truncated at the top of the word
  assign ins_l    = (span >= EXT_W'(DATA_W)) ? '0 : (EXT_W'(DATA_W) - span);

  always_comb begin
    if (op_i == OP_EXTRACT) begin
      rot_o  = CNT_W'(EXT_W'(DATA_W) - EXT_W'(shift));
      lcnt_o = ext_l[CNT_W-1:0];
      rcnt_o = '0;
    end else begin
      rot_o  = shift;
      lcnt_o = ins_l[CNT_W-1:0];
      rcnt_o = shift;
    end
  end

  // R6: insert masks never overlap past the word
  always_comb begin
    if (op_i == OP_INSERT)
      a_r6_mask_fit: assert ((EXT_W'(lcnt_o) + EXT_W'(rcnt_o)) <= EXT_W'(DATA_W));
  end
endmodule

// File: rtl/bfu_rotator.sv
// Logarithmic left rotator
module bfu_rotator #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int unsigned R = 1 << k;
    logic [DATA_W-1:0] rotd;
    assign rotd = {stage[k][DATA_W-1-R:0], stage[k][DATA_W-1:DATA_W-R]};
    assign stage[k+1] = amt_i[k] ? rotd : stage[k];
  end

  assign data_o = stage[CNT_W];
endmodule

// File: rtl/bfu_mask_gen.sv
// Field mask: clears upper lcnt bits and lower rcnt bits
module bfu_mask_gen #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0]  lcnt_i,
  input  logic [CNT_W-1:0]  rcnt_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [CNT_W:0] hi_lim;

  assign hi_lim = (CNT_W+1)'(DATA_W) - {1'b0, lcnt_i};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask_o[i] = ((CNT_W+1)'(i) < hi_lim) && ((CNT_W+1)'(i) >= {1'b0, rcnt_i});
  end
endmodule

// File: rtl/bfu_field_unit.sv
module bfu_field_unit
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [2*CNT_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  bfu_op_e           op;
  logic [CNT_W-1:0]  rot_amt, lcnt, rcnt;
  logic [DATA_W-1:0] rot_in, rot_out, fmask, merged;

  assign op = bfu_op_e'(op_i);

  bfu_ctl_gen #(.DATA_W(DATA_W)) u_ctl (
    .op_i   (op),
    .ctrl_i (ctrl_i),
    .rot_o  (rot_amt),
    .lcnt_o (lcnt),
    .rcnt_o (rcnt)
  );

  assign rot_in = (op == OP_EXTRACT) ? a_i : b_i;

  bfu_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i (rot_in),
    .amt_i  (rot_amt),
    .data_o (rot_out)
  );

  bfu_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .lcnt_i (lcnt),
    .rcnt_i (rcnt),
    .mask_o (fmask)
  );

  always_comb begin
    if (op == OP_EXTRACT) merged = rot_out & fmask;
    else                  merged = (a_i & ~fmask) | (rot_out & fmask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) result_o <= merged;
    end
  end

  a_r3_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  a_r3_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));
  a_r4_outside_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i) |-> (((merged ^ a_i) & ~fmask) == '0));
  a_r2_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i && ctrl_i[2*CNT_W-1:CNT_W] != '0)
      |-> ((merged >> ctrl_i[2*CNT_W-1:CNT_W]) == '0));
endmodule

// File: tb/tb_bfu_field_unit.sv
`timescale 1ns/1ps
module tb_bfu_field_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [7:0]  ctrl_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] result_o;
  logic        done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  bfu_field_unit dut (
    .clk_i, .rst_ni, .start_i, .op_i, .ctrl_i, .a_i, .b_i, .result_o, .done_o
  );

  typedef struct packed {
    logic        op;
    logic [7:0]  ctrl;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h44, 16'h1234, 16'h0000, 16'h0003},
    '{1'b0, 8'h80, 16'hABCD, 16'h0000, 16'h00CD},
    '{1'b0, 8'h0C, 16'h1234, 16'h0000, 16'h2341},
    '{1'b0, 8'h8C, 16'h1234, 16'h0000, 16'h0041},
    '{1'b0, 8'h1F, 16'h8000, 16'h0000, 16'h0001},
    '{1'b0, 8'hF1, 16'hFFFF, 16'h0000, 16'h7FFF},
    '{1'b1, 8'h44, 16'hFFFF, 16'h0000, 16'hFF0F},
    '{1'b1, 8'h84, 16'h0000, 16'h12AB, 16'h0AB0},
    '{1'b1, 8'h8C, 16'h1234, 16'h00FF, 16'hF234},
    '{1'b1, 8'h00, 16'h1234, 16'hBEEF, 16'hBEEF},
    '{1'b1, 8'h08, 16'h1234, 16'h00CD, 16'hCD34},
    '{1'b1, 8'h1F, 16'h0000, 16'h0001, 16'h8000}
  };

  function automatic logic [15:0] model(logic op, logic [7:0] ctrl, logic [15:0] a, logic [15:0] b);
    int s = int'(ctrl[3:0]);
    int w = (ctrl[7:4] == 4'd0) ? 16 : int'(ctrl[7:4]);
    logic [15:0] r;
    if (!op) begin
      r = '0;
      for (int i = 0; i < w; i++) r[i] = a[(i + s) % 16];
    end else begin
      r = a;
      for (int i = 0; i < w; i++) if (s + i < 16) r[s + i] = b[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic op, logic [7:0] ctrl, logic [15:0] a, logic [15:0] b);
    @(negedge clk_i);
    op_i = op; ctrl_i = ctrl; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] held;
    repeat (3) @(negedge clk_i);
    check("R8 reset result", result_o, 16'h0000);
    check("R8 reset done", {15'd0, done_o}, 16'h0000);
    rst_ni = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].op, VECS[v].ctrl, VECS[v].a, VECS[v].b);
      check(VECS[v].op ? "R4 R5 R6 R7 insert vector" : "R1 R2 R7 extract vector",
            result_o, VECS[v].exp);
      check("R3 done after start", {15'd0, done_o}, 16'h0001);
    end

    // R3: done drops when start is low; R9: result holds while inputs change
    @(negedge clk_i);
    start_i = 1'b0;
    held = result_o;
    @(negedge clk_i);
    check("R3 done low without start", {15'd0, done_o}, 16'h0000);
    op_i = 1'b0; ctrl_i = 8'h00; a_i = 16'h5A5A; b_i = 16'hA5A5;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 result held", result_o, held);
    check("R3 done stays low", {15'd0, done_o}, 16'h0000);

    // exhaustive control-byte sweep, both operations
    for (int op = 0; op < 2; op++) begin
      for (int c = 0; c < 256; c++) begin
        logic [15:0] ra, rb;
        lfsr = lfsr ^ (lfsr << 7); lfsr = lfsr ^ (lfsr >> 9); lfsr = lfsr ^ (lfsr << 8);
        ra = lfsr;
        lfsr = lfsr ^ (lfsr << 7); lfsr = lfsr ^ (lfsr >> 9); lfsr = lfsr ^ (lfsr << 8);
        rb = lfsr;
        run_op(op[0], c[7:0], ra, rb);
        check(op[0] ? "R4 R5 R6 sweep insert" : "R1 R2 sweep extract",
              result_o, model(op[0], c[7:0], ra, rb));
      end
    end

    // R6: truncated insert with all-ones data must not touch low bits
    run_op(1'b1, 8'hFA, 16'h0000, 16'hFFFF);
    check("R6 truncation no wrap", result_o, 16'hFC00);
    // R7: full-width extract is a pure rotate
    run_op(1'b0, 8'h01, 16'h0001, 16'h0000);
    check("R7 full width rotate", result_o, 16'h8000);

    // R8: asynchronous reset clears state mid-run
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R8 async reset result", result_o, 16'h0000);
    check("R8 async reset done", {15'd0, done_o}, 16'h0000);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule